// File: doc/BRIEF.md
# Distributed Shared-Memory Intermediate Port Selector

This block is the central cell scheduler of a switch whose buffer memory is spread across the linecards of its N ports. The ports are joined by a crossbar that runs faster than the line rate. Each arriving cell must be parked in one port's memory, the intermediate port, until it leaves. For every cell the selector receives the input port, the output port and how many slots ahead the cell is due to leave. It then chooses the intermediate port.

A port can take the cell only if two conditions hold. Its crossbar write path still has room in the current slot, which holds at most two writes per port. Its read path still has room in the departure slot, which holds at most two booked reads per port. Of the ports that qualify, the one with the lowest index wins. The write use and the read use are both booked in the same cycle. When no port qualifies, a failure pulse is raised and nothing is booked.

Departure times come from elsewhere, and cells are handed over one per cycle. A slot tick starts each new slot. The selector keeps a ring of future slots and shows the per-port read bookings of the slot now being served, so the read side of the crossbar can be set up.

Top module: `dsm_xport_sched`

## Requirements
- R1: After reset, `gnt_valid` and `gnt_fail` are 0, every field of `now_reads` is 0, and no writes or reads are booked in any slot.
- R2: A request with `req_valid`=1 and `slot_tick`=0 is answered on the next cycle. Either `gnt_valid`=1 with `gnt_port` set to the lowest-index port that qualifies, or `gnt_fail`=1. A port qualifies when it has fewer than WCAP (2) writes in the current slot and fewer than RCAP (2) reads booked in the target slot.
- R3: No port is granted more than WCAP (2) writes between two slot ticks.
- R4: No port gets more than RCAP (2) reads booked for one departure slot, even when the bookings are made across several earlier slots.
- R5: When no port qualifies, `gnt_fail`=1 and `gnt_valid`=0 for one cycle, and no write count or read booking changes.
- R6: `slot_tick`=1 clears every write count and moves the current slot forward by one, wrapping after HORIZON (16). The bookings of the slot being left are cleared, so that ring entry starts empty when it comes round again.
- R7: A request presented in the same cycle as `slot_tick` is ignored. No grant and no failure follow, and nothing is booked.
- R8: `gnt_src` and `gnt_dst` repeat the `req_src` and `req_dst` of the request being answered.
- R9: `req_ofs` is the number of slots ahead of the current slot (0 to HORIZON-1). Offset 0 books into the current slot, and `now_reads` (field p at bits [p*2+1:p*2]) shows that booking on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | Start of the next cell slot |
| req_valid | input | 1 | A cell awaits placement this cycle |
| req_src | input | PW | Input port of the cell |
| req_dst | input | PW | Output port of the cell |
| req_ofs | input | SW | Departure slot, in slots ahead of the current one |
| gnt_valid | output | 1 | The previous cycle's request was placed |
| gnt_port | output | PW | Chosen intermediate port |
| gnt_src | output | PW | Input port of the answered request |
| gnt_dst | output | PW | Output port of the answered request |
| gnt_fail | output | 1 | The previous cycle's request found no eligible port |
| now_reads | output | NPORT*CW | Reads booked per port for the current slot |

## Verification
The bench goes after these corner cases:
- The seventeenth write in one slot (2 × 8 ports, plus one), which must fail. A selector that checked only the read side would grant it and overrun a write path.
- A departure slot filled by bookings made over two earlier slots. A design that kept read counts per request slot rather than per departure slot would place a third read on a port.
- Requests that arrive together with a tick, which must leave no trace.
- Offset 0 and offset HORIZON-1, which expose wrap errors in the ring index.
- Ring entries revisited after a full turn, which show up stale bookings from a missed clear as wrong `now_reads` values.

// File: rtl/dsm_sched_pkg.sv
// Shared helpers for the intermediate port selector.
// Assumes ring offsets are always smaller than the ring depth.
package dsm_sched_pkg;

    // Index into a ring of 'depth' entries, 'ofs' places after 'base'.
    function automatic int unsigned ring_add(int unsigned base, int unsigned ofs,
                                             int unsigned depth);
        int unsigned s;
        s = base + ofs;
        return (s >= depth) ? s - depth : s;
    endfunction

endpackage

// File: rtl/xs_wr_track.sv
// Per-port write counters for the current slot.
// Counts grants per intermediate port and reports which ports remain under
// the write cap. Assumes 'inc' never targets a port already at the cap.
module xs_wr_track #(
    parameter int NPORT = 8,
    parameter int CAP   = 2,
    parameter int CW    = 2,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  inc,
    input  logic [PW-1:0]         inc_port,
    output logic [NPORT*CW-1:0]   cnt_flat,
    output logic [NPORT-1:0]      ok_vec
);
    logic [CW-1:0] cnt [NPORT];

    // Clear on reset or slot tick, else count the granted port.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int p = 0; p < NPORT; p++) cnt[p] <= '0;
        end else if (inc) begin
            for (int p = 0; p < NPORT; p++)
                if (inc_port == PW'(p)) cnt[p] <= cnt[p] + CW'(1);
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        // Report headroom and expose the count.
        assign ok_vec[g]             = cnt[g] < CW'(CAP);
        assign cnt_flat[g*CW +: CW]  = cnt[g];
    end
endmodule

// File: rtl/xs_rd_book.sv
// Circular table of read bookings, DEPTH future slots by NPORT ports.
// A pointer marks the current slot. The pointer's row is output and is
// cleared as the pointer advances. Assumes look_ofs < DEPTH.
module xs_rd_book #(
    parameter int NPORT = 8,
    parameter int DEPTH = 16,
    parameter int CAP   = 2,
    parameter int CW    = 2,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic [SW-1:0]         look_ofs,
    input  logic                  book,
    input  logic [PW-1:0]         book_port,
    output logic [NPORT*CW-1:0]   now_flat,
    output logic [NPORT-1:0]      ok_vec
);
    import dsm_sched_pkg::*;

    logic [CW-1:0] tbl [DEPTH][NPORT];
    logic [SW-1:0] ptr;
    logic [SW-1:0] row_sel;

    // Row addressed by the request's offset from the current slot.
    always_comb row_sel = SW'(ring_add(int'(ptr), int'(look_ofs), DEPTH));

    // Move the slot pointer on each tick, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= (ptr == SW'(DEPTH - 1)) ? '0 : ptr + SW'(1);
    end

    // Clear the row being left on a tick; add one booking on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++)
                for (int p = 0; p < NPORT; p++) tbl[r][p] <= '0;
        end else if (adv) begin
            for (int p = 0; p < NPORT; p++) tbl[ptr][p] <= '0;
        end else if (book) begin
            tbl[row_sel][book_port] <= tbl[row_sel][book_port] + CW'(1);
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        // Headroom in the looked-up row, and the current row's counts.
        assign ok_vec[g]            = tbl[row_sel][g] < CW'(CAP);
        assign now_flat[g*CW +: CW] = tbl[ptr][g];
    end
endmodule

// File: rtl/xs_pick.sv
// Lowest-index selector over an eligibility vector.
// Purely combinational; 'idx' is zero when 'any' is low.
module xs_pick #(
    parameter int NPORT = 8,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0] elig,
    output logic             any,
    output logic [PW-1:0]    idx
);
    // Scan from the top down so the lowest set bit is the one kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (elig[p]) begin
                any = 1'b1;
                idx = PW'(p);
            end
        end
    end
endmodule

// File: rtl/dsm_xport_sched.sv
// Intermediate port selector for a distributed shared-memory switch.
// Accepts one cell per cycle, with its source, destination and departure
// offset. Picks the lowest port that has write headroom now and read headroom
// at the departure slot, books both, and answers one cycle later.
// Assumes departure offsets are below HORIZON. A request in a tick cycle is
// dropped.
module dsm_xport_sched #(
    parameter int NPORT   = 8,
    parameter int HORIZON = 16,
    parameter int WCAP    = 2,
    parameter int RCAP    = 2,
    localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int SW     = (HORIZON > 1) ? $clog2(HORIZON) : 1,
    localparam int CMAX   = (WCAP > RCAP) ? WCAP : RCAP,
    localparam int CW     = $clog2(CMAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_tick,
    input  logic                 req_valid,
    input  logic [PW-1:0]        req_src,
    input  logic [PW-1:0]        req_dst,
    input  logic [SW-1:0]        req_ofs,
    output logic                 gnt_valid,
    output logic [PW-1:0]        gnt_port,
    output logic [PW-1:0]        gnt_src,
    output logic [PW-1:0]        gnt_dst,
    output logic                 gnt_fail,
    output logic [NPORT*CW-1:0]  now_reads
);
    logic                 accept;
    logic                 hit;
    logic                 any_ok;
    logic [PW-1:0]        pick;
    logic [NPORT-1:0]     w_ok;
    logic [NPORT-1:0]     r_ok;
    logic [NPORT-1:0]     elig;
    logic [NPORT*CW-1:0]  w_cnt_flat;

    // A request counts only outside tick cycles; book only when a port fits.
    always_comb begin
        accept = req_valid && !slot_tick;
        elig   = w_ok & r_ok;
        hit    = accept && any_ok;
    end

    xs_wr_track #(.NPORT(NPORT), .CAP(WCAP), .CW(CW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (slot_tick),
        .inc      (hit),
        .inc_port (pick),
        .cnt_flat (w_cnt_flat),
        .ok_vec   (w_ok)
    );

    xs_rd_book #(.NPORT(NPORT), .DEPTH(HORIZON), .CAP(RCAP), .CW(CW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (slot_tick),
        .look_ofs  (req_ofs),
        .book      (hit),
        .book_port (pick),
        .now_flat  (now_reads),
        .ok_vec    (r_ok)
    );

    xs_pick #(.NPORT(NPORT)) u_pick (
        .elig (elig),
        .any  (any_ok),
        .idx  (pick)
    );

    // Register the answer to this cycle's request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_fail  <= 1'b0;
            gnt_port  <= '0;
            gnt_src   <= '0;
            gnt_dst   <= '0;
        end else begin
            gnt_valid <= hit;
            gnt_fail  <= accept && !any_ok;
            gnt_port  <= pick;
            gnt_src   <= req_src;
            gnt_dst   <= req_dst;
        end
    end
endmodule

// File: rtl/dsm_xport_chk.sv
// Property checker for the intermediate port selector, bound to its top.
module dsm_xport_chk #(
    parameter int NPORT = 8,
    parameter int WCAP  = 2,
    parameter int RCAP  = 2,
    parameter int PW    = 3,
    parameter int CW    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 slot_tick,
    input logic                 req_valid,
    input logic [PW-1:0]        req_src,
    input logic [PW-1:0]        req_dst,
    input logic                 gnt_valid,
    input logic                 gnt_fail,
    input logic [PW-1:0]        gnt_src,
    input logic [PW-1:0]        gnt_dst,
    input logic [NPORT*CW-1:0]  now_reads,
    input logic [NPORT*CW-1:0]  w_cnt_flat
);
    // R2
    grant_xor_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_valid && gnt_fail));

    // R7
    tick_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> !gnt_valid && !gnt_fail);

    // R2
    idle_no_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !gnt_valid && !gnt_fail);

    // R8
    echo_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !slot_tick) |=> (gnt_src == $past(req_src)) &&
                                      (gnt_dst == $past(req_dst)));

    // R6
    tick_clears_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> (w_cnt_flat == '0));

    for (genvar g = 0; g < NPORT; g++) begin : g_cap
        // R3
        write_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            w_cnt_flat[g*CW +: CW] <= CW'(WCAP));
        // R4
        read_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            now_reads[g*CW +: CW] <= CW'(RCAP));
    end
endmodule

bind dsm_xport_sched dsm_xport_chk #(
    .NPORT(NPORT), .WCAP(WCAP), .RCAP(RCAP), .PW(PW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_tick  (slot_tick),
    .req_valid  (req_valid),
    .req_src    (req_src),
    .req_dst    (req_dst),
    .gnt_valid  (gnt_valid),
    .gnt_fail   (gnt_fail),
    .gnt_src    (gnt_src),
    .gnt_dst    (gnt_dst),
    .now_reads  (now_reads),
    .w_cnt_flat (w_cnt_flat)
);

// File: tb/sim_dsm_xport_sched.sv
// Bench: behavioural model of slot-indexed bookings, compared every cycle.
module sim_dsm_xport_sched;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int H  = 16;
    localparam int WC = 2;
    localparam int RC = 2;
    localparam int PW = 3;
    localparam int SW = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_tick = 1'b0;
    logic req_valid = 1'b0;
    logic [PW-1:0] req_src = '0;
    logic [PW-1:0] req_dst = '0;
    logic [SW-1:0] req_ofs = '0;
    logic gnt_valid, gnt_fail;
    logic [PW-1:0] gnt_port, gnt_src, gnt_dst;
    logic [N*CW-1:0] now_reads;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsm_xport_sched #(.NPORT(N), .HORIZON(H), .WCAP(WC), .RCAP(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .req_valid(req_valid),
        .req_src(req_src), .req_dst(req_dst), .req_ofs(req_ofs),
        .gnt_valid(gnt_valid), .gnt_port(gnt_port), .gnt_src(gnt_src),
        .gnt_dst(gnt_dst), .gnt_fail(gnt_fail), .now_reads(now_reads)
    );

    int total = 0;
    int bad = 0;
    int wcnt [N];
    int rbook [H][N];
    int cur = 0;
    int e_valid = 0, e_fail = 0, e_port = 0, e_src = 0, e_dst = 0;
    string tag = "R1";
    bit done = 0;

    task automatic chk(string rq, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < N; p++) wcnt[p] = 0;
        for (int r = 0; r < H; r++)
            for (int p = 0; p < N; p++) rbook[r][p] = 0;
        cur = 0; e_valid = 0; e_fail = 0; e_port = 0; e_src = 0; e_dst = 0;
    endtask

    // Compare the outputs with the model, then drive one cycle and advance the model.
    task automatic step(bit v, int s, int d, int ofs, bit tk);
        int row, pk;
        @(negedge clk);
        chk(tag, "gnt_valid", int'(gnt_valid), e_valid);
        chk(tag, "gnt_fail R5", int'(gnt_fail), e_fail);
        if (e_valid != 0) begin
            chk(tag, "gnt_port", int'(gnt_port), e_port);
            chk("R8", "gnt_src", int'(gnt_src), e_src);
            chk("R8", "gnt_dst", int'(gnt_dst), e_dst);
        end
        for (int p = 0; p < N; p++)
            chk("R4/R6", "now_reads", int'(now_reads[p*CW +: CW]), rbook[cur][p]);
        req_valid = v; req_src = PW'(s); req_dst = PW'(d); req_ofs = SW'(ofs);
        slot_tick = tk;
        e_valid = 0; e_fail = 0; e_src = s; e_dst = d;
        if (tk) begin
            for (int p = 0; p < N; p++) wcnt[p] = 0;
            for (int p = 0; p < N; p++) rbook[cur][p] = 0;
            cur = (cur + 1) % H;
        end else if (v) begin
            row = (cur + ofs) % H;
            pk = -1;
            for (int p = N - 1; p >= 0; p--)
                if (wcnt[p] < WC && rbook[row][p] < RC) pk = p;
            if (pk < 0) e_fail = 1;
            else begin
                e_valid = 1; e_port = pk;
                wcnt[pk]++; rbook[row][pk]++;
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        @(negedge clk);
        chk("R1", "gnt_valid", int'(gnt_valid), 0);
        chk("R1", "gnt_fail", int'(gnt_fail), 0);
        chk("R1", "now_reads", int'(now_reads), 0);

        // R3: fill every write path in one slot with distinct offsets, then one more
        tag = "R3";
        for (int k = 0; k < 2 * N; k++) step(1, k % N, (k + 1) % N, k % H, 0);
        tag = "R3/R5";
        step(1, 2, 3, 5, 0);
        step(0, 0, 0, 0, 0);

        // R9: offset 0 lands in the current slot
        tag = "R9";
        step(0, 0, 0, 0, 1);
        step(1, 4, 1, 0, 0);
        step(1, 5, 2, 0, 0);
        step(1, 6, 3, 0, 0);
        step(0, 0, 0, 0, 0);

        // R4: one departure slot filled from two earlier slots, then a third try
        tag = "R4";
        step(0, 0, 0, 0, 1);
        for (int k = 0; k < N; k++) step(1, k, 0, 6, 0);
        step(0, 0, 0, 0, 1);
        for (int k = 0; k < N; k++) step(1, k, 0, 5, 0);
        step(0, 0, 0, 0, 1);
        tag = "R4/R5";
        step(1, 1, 0, 4, 0);
        step(1, 2, 1, 3, 0);

        // R7: request alongside a tick leaves no trace
        tag = "R7";
        step(1, 3, 3, 0, 1);
        step(0, 0, 0, 0, 0);
        step(1, 3, 3, H - 1, 0);

        // R6: a full turn of the ring clears old entries
        tag = "R6";
        for (int k = 0; k < H + 2; k++) step(0, 0, 0, 0, 1);

        // R2: random traffic against the model
        tag = "R2";
        for (int k = 0; k < 4000; k++)
            step(($urandom % 4) != 0, $urandom % N, $urandom % N, $urandom % H,
                 ($urandom % 9) == 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule